// File: doc/BRIEF.md
# Per-Field VBI Byte Splitter

This block sits on a byte stream that carries vertical-blanking-interval (VBI) data and active picture data mixed together, one field after another. A field-start pulse marks the beginning of each field and carries the field parity. From that point the block counts the bytes that arrive. Bytes whose index falls below the budget programmed for that parity are treated as VBI data. Every later byte in the field is active video.

VBI bytes reach the encoder side only while the current horizontal pixel position lies inside a programmable window. A VBI byte that arrives outside the window is dropped. It is never sent to the video side. Video bytes are never gated by the window. The block produces two output streams, each with its own valid strobe. Four configuration registers, written through a small address/data port, hold the window edges and the two per-parity budgets.

Top module: `vbi_splitter`

## Requirements
- R1: After reset, all four configuration registers read as zero and both output strobes are low. With that configuration, any byte is delivered as active video.
- R2: A write takes the low bits of `cfg_wdata` into the register chosen by `cfg_addr`: 0 is the window start, 1 is the window end, 2 is the odd-field budget and 3 is the even-field budget. The window edges are 11 bits wide and the budgets are 20 bits wide.
- R3: A field-start pulse clears the byte count. It also latches the parity (`in_odd` = 1 means odd, 0 means even). The latched parity selects the budget for the whole field, even if `in_odd` changes later.
- R4: Within a field, bytes with index 0 up to budget-1 are VBI bytes. Every byte from index equal to the budget onward goes to the video output.
- R5: Odd fields use the odd budget and even fields use the even budget. The two budgets are independent.
- R6: A budget of zero sends every byte of that field to the video output.
- R7: A VBI byte is forwarded only when `hpos` is at least the window start and strictly below the window end.
- R8: When the window end is less than or equal to the window start, no VBI byte is forwarded, and such bytes never appear on the video output.
- R9: The two output strobes are never high in the same cycle. Each output appears one clock after its input byte and carries that byte's data. No output appears for a cycle without `in_valid`.
- R10: A byte that arrives in the same cycle as a field-start pulse is byte 0 of the new field. It is classified with the parity given in that cycle.
- R11: A configuration write that happens in the same cycle as a byte does not affect that byte. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 20 | Configuration write data |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_odd | input | 1 | Field parity, sampled on field start |
| field_start | input | 1 | First-cycle-of-field pulse |
| hpos | input | 11 | Current horizontal pixel position |
| vbi_valid | output | 1 | VBI output strobe |
| vbi_data | output | 8 | VBI output byte |
| vid_valid | output | 1 | Active-video output strobe |
| vid_data | output | 8 | Active-video output byte |

## Verification
Two events can land in the same cycle. A field-start pulse can coincide with a byte, and a configuration write can coincide with a byte that depends on the register being written. The first case is provoked at the head of every field in the vector table. It is judged by whether that byte is classified as index 0 under the new parity. The second case is a directed test that raises the odd budget in the very cycle of a byte. It expects that byte to follow the old budget and the next field to follow the new one.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
   typedef enum logic [1:0] {
      REG_WIN_START   = 2'd0,
      REG_WIN_END     = 2'd1,
      REG_BUDGET_ODD  = 2'd2,
      REG_BUDGET_EVEN = 2'd3
   } vbi_reg_e;
endpackage

// File: rtl/vbi_cfg_regs.sv
module vbi_cfg_regs
   import vbi_pkg::*;
#(
   parameter int HPOS_W = 11,
   parameter int CNT_W  = 20,
   localparam int CFG_W = (CNT_W > HPOS_W) ? CNT_W : HPOS_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [HPOS_W-1:0] win_start,
   output logic [HPOS_W-1:0] win_end,
   output logic [CNT_W-1:0]  bud_odd,
   output logic [CNT_W-1:0]  bud_even
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_start <= '0;
         win_end   <= '0;
         bud_odd   <= '0;
         bud_even  <= '0;
      end else if (cfg_we) begin
         case (vbi_reg_e'(cfg_addr))
            REG_WIN_START:   win_start <= cfg_wdata[HPOS_W-1:0];
            REG_WIN_END:     win_end   <= cfg_wdata[HPOS_W-1:0];
            REG_BUDGET_ODD:  bud_odd   <= cfg_wdata[CNT_W-1:0];
            REG_BUDGET_EVEN: bud_even  <= cfg_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // R2
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(win_start) && $stable(win_end) && $stable(bud_odd) && $stable(bud_even)));
endmodule

// File: rtl/vbi_field_counter.sv
module vbi_field_counter #(
   parameter int CNT_W = 20
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_odd,
   input  logic             field_start,
   input  logic [CNT_W-1:0] bud_odd,
   input  logic [CNT_W-1:0] bud_even,
   output logic             is_vbi
);
   logic [CNT_W-1:0] cnt_q, cnt_eff;
   logic             odd_q, odd_eff;
   logic [CNT_W-1:0] budget;

   always_comb begin
      cnt_eff = field_start ? '0 : cnt_q;
      odd_eff = field_start ? in_odd : odd_q;
      budget  = odd_eff ? bud_odd : bud_even;
      is_vbi  = in_valid && (cnt_eff < budget);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         odd_q <= 1'b0;
      end else begin
         odd_q <= odd_eff;
         if (in_valid && (cnt_eff != '1)) cnt_q <= cnt_eff + 1'b1;
         else                             cnt_q <= cnt_eff;
      end
   end

   // R3
   fs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (field_start && !in_valid) |=> (cnt_q == '0));
   // R10
   fs_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (field_start && in_valid) |=> (cnt_q == CNT_W'(1)));
   // R3
   parity_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> (odd_q == $past(in_odd)));
endmodule

// File: rtl/vbi_hwindow.sv
module vbi_hwindow #(
   parameter int HPOS_W = 11
)(
   input  logic [HPOS_W-1:0] hpos,
   input  logic [HPOS_W-1:0] win_start,
   input  logic [HPOS_W-1:0] win_end,
   output logic              in_win
);
   always_comb begin
      in_win = (hpos >= win_start) && (hpos < win_end);
   end

   // R8
   always_comb begin
      if (win_end <= win_start) empty_win_chk: assert (!in_win);
   end
endmodule

// File: rtl/vbi_splitter.sv
module vbi_splitter #(
   parameter int HPOS_W  = 11,
   parameter int CNT_W   = 20,
   parameter int DATA_W  = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int CFG_W  = (CNT_W > HPOS_W) ? CNT_W : HPOS_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_odd,
   input  logic              field_start,
   input  logic [HPOS_W-1:0] hpos,
   output logic              vbi_valid,
   output logic [DATA_W-1:0] vbi_data,
   output logic              vid_valid,
   output logic [DATA_W-1:0] vid_data
);
   generate
      if (HPOS_W < 2 || HPOS_W > 16) begin : g_bad_hpos
         $error("vbi_splitter: HPOS_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("vbi_splitter: CNT_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("vbi_splitter: DATA_W must be positive");
      end
   endgenerate

   logic [HPOS_W-1:0] win_start, win_end;
   logic [CNT_W-1:0]  bud_odd, bud_even;
   logic              is_vbi, in_win;
   logic              vbi_hit, vid_hit;

   vbi_cfg_regs #(.HPOS_W(HPOS_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .win_start(win_start), .win_end(win_end),
      .bud_odd(bud_odd), .bud_even(bud_even)
   );

   vbi_field_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_odd(in_odd),
      .field_start(field_start), .bud_odd(bud_odd), .bud_even(bud_even),
      .is_vbi(is_vbi)
   );

   vbi_hwindow #(.HPOS_W(HPOS_W)) u_win (
      .hpos(hpos), .win_start(win_start), .win_end(win_end), .in_win(in_win)
   );

   always_comb begin
      vbi_hit = is_vbi && in_win;
      vid_hit = in_valid && !is_vbi;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vbi_valid <= 1'b0;
               vid_valid <= 1'b0;
               vbi_data  <= '0;
               vid_data  <= '0;
            end else begin
               vbi_valid <= vbi_hit;
               vid_valid <= vid_hit;
               vbi_data  <= vbi_hit ? in_data : '0;
               vid_data  <= vid_hit ? in_data : '0;
            end
         end

         // R9
         out_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vbi_valid || vid_valid) |-> $past(in_valid));
         // R9
         vid_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vid_valid |-> (vid_data == $past(in_data)));
      end else begin : g_comb
         always_comb begin
            vbi_valid = vbi_hit;
            vid_valid = vid_hit;
            vbi_data  = vbi_hit ? in_data : '0;
            vid_data  = vid_hit ? in_data : '0;
         end
      end
   endgenerate

   // R9
   excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(vbi_valid && vid_valid));
endmodule

// File: tb/vbi_splitter_tb.sv
module vbi_splitter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [19:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_odd = 1'b0;
   logic        field_start = 1'b0;
   logic [10:0] hpos = '0;
   logic        vbi_valid, vid_valid;
   logic [7:0]  vbi_data, vid_data;

   int vectors = 0;
   int miscompares = 0;

   always #4 clk = ~clk;

   vbi_splitter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
      .in_odd(in_odd), .field_start(field_start), .hpos(hpos),
      .vbi_valid(vbi_valid), .vbi_data(vbi_data),
      .vid_valid(vid_valid), .vid_data(vid_data)
   );

   // expected: 0 none, 1 vbi, 2 video.  {fs, odd, hpos[10:0], exp[1:0]}
   // window [10,20), odd budget 3, even budget 2
   localparam int NV = 12;
   localparam logic [14:0] VEC [NV] = '{
      {1'b1, 1'b1, 11'd10, 2'd1},   // R10 R7 start inclusive
      {1'b0, 1'b1, 11'd19, 2'd1},   // R4
      {1'b0, 1'b1, 11'd20, 2'd0},   // R7 end excluded
      {1'b0, 1'b1, 11'd15, 2'd2},   // R4 index == budget
      {1'b0, 1'b1, 11'd15, 2'd2},
      {1'b1, 1'b0, 11'd12, 2'd1},   // R5 even field
      {1'b0, 1'b1, 11'd9,  2'd0},   // R3 parity latched, R7 before start
      {1'b0, 1'b0, 11'd12, 2'd2},   // R5 even budget 2
      {1'b1, 1'b1, 11'd11, 2'd1},
      {1'b0, 1'b0, 11'd11, 2'd1},
      {1'b0, 1'b0, 11'd11, 2'd1},
      {1'b0, 1'b0, 11'd11, 2'd2}
   };

   task automatic check(input string req, input int exp, input logic [7:0] d);
      logic ev, evd;
      ev  = (exp == 1);
      evd = (exp == 2);
      vectors++;
      if (vbi_valid !== ev || vid_valid !== evd ||
          (ev && vbi_data !== d) || (evd && vid_data !== d)) begin
         miscompares++;
         $display("FAIL %s: vbi=%b/%h vid=%b/%h, expected vbi=%b vid=%b data=%h",
                  req, vbi_valid, vbi_data, vid_valid, vid_data, ev, evd, d);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [19:0] v);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push(input logic fs, input logic odd, input logic [10:0] hp,
                       input logic [7:0] d, input string req, input int exp);
      in_valid = 1'b1; field_start = fs; in_odd = odd; hpos = hp; in_data = d;
      @(negedge clk);
      in_valid = 1'b0; field_start = 1'b0;
      check(req, exp, d);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset outputs", 0, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      push(1'b1, 1'b1, 11'd5, 8'hA5, "R1 zero config gives video", 2);

      // R2: program registers by address
      wr(2'd0, 20'd10);
      wr(2'd1, 20'd20);
      wr(2'd2, 20'd3);
      wr(2'd3, 20'd2);

      for (int i = 0; i < NV; i++) begin
         push(VEC[i][14], VEC[i][13], VEC[i][12:2], 8'(8'h40 + i),
              "R2 R4 table vector", int'(VEC[i][1:0]));
      end

      // R9: idle cycle yields nothing
      @(negedge clk);
      check("R9 no input no output", 0, 8'h00);

      // R6: zero odd budget
      wr(2'd2, 20'd0);
      push(1'b1, 1'b1, 11'd12, 8'h11, "R6 zero budget", 2);
      push(1'b0, 1'b1, 11'd12, 8'h12, "R6 zero budget", 2);

      // R11: write odd budget in the same cycle as a byte
      cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 20'd1;
      push(1'b1, 1'b1, 11'd12, 8'h21, "R11 old budget for same-cycle byte", 2);
      cfg_we = 1'b0;
      push(1'b1, 1'b1, 11'd12, 8'h22, "R11 new budget next field", 1);

      // R8: empty window drops VBI bytes
      wr(2'd2, 20'd5);
      wr(2'd1, 20'd10);
      push(1'b1, 1'b1, 11'd10, 8'h31, "R8 end equals start", 0);
      wr(2'd1, 20'd4);
      push(1'b0, 1'b1, 11'd5, 8'h32, "R8 end below start", 0);
      push(1'b0, 1'b1, 11'd10, 8'h33, "R8 end below start", 0);

      // R3: field start without a byte clears count
      wr(2'd1, 20'd20);
      field_start = 1'b1; in_odd = 1'b0;
      @(negedge clk);
      field_start = 1'b0;
      push(1'b0, 1'b1, 11'd15, 8'h41, "R3 even latched, byte 0", 1);
      push(1'b0, 1'b1, 11'd15, 8'h42, "R3 even latched, byte 1", 1);
      push(1'b0, 1'b1, 11'd15, 8'h43, "R3 even budget reached", 2);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule